// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block merges the interrupt requests of a small companion chip into one line towards the host. Four GPIO bank summary lines and six peripheral event inputs feed a 10-bit pending-status vector. The low four bits mirror the bank summaries, which are cleared at the banks themselves. The upper six bits are sticky latches for the peripheral events, and software clears them by writing ones. A per-peripheral enable mask and one global enable decide whether a pending bit drives the upstream line.

The host treats the upstream line as a rising-edge request. Its handler reads the status word, services every bank and peripheral that is set, acknowledges the peripheral bits, and reads again until the word is zero. A write to the status word pulls the line low for one cycle. If anything is still pending, or arrives meanwhile, the host therefore sees a new rising edge rather than a line that stayed high. Access is through a simple register port: one write strobe, an address, write data, and read data that follows the address within the same cycle.

Top module: `irqagg_top`

## Requirements
- R1: After synchronous reset, the status word (address 0) reads 0, the enable word (address 1) reads 0 and `irq_o` is low.
- R2: Status bits 3..0 show the bank summary inputs `bank_sum_i[3..0]` one clock after they are sampled, bank A at bit 0. Status writes do not change them.
- R3: A one-cycle pulse on `periph_evt_i[j]` sets status bit 4+j. The bit stays set until a write to address 0 has a 1 at bit 4+j. A 0 in that write position leaves it set.
- R4: When an event on peripheral j and a write-one-clear of bit 4+j fall in the same cycle, the bit is set afterwards.
- R5: The enable word at address 1 is read/write. Bits 5..0 enable peripheral sources 0..5 (1 = enabled), and bit 15 is the global enable. All other bits read 0. The word changes only when written.
- R6: One clock after the state allows it, `irq_o` is high when the global enable is set and at least one bank bit or one enabled peripheral bit is pending. A pending peripheral bit whose enable is 0 remains visible in the status word but does not raise `irq_o`.
- R7: While the global enable is 0, `irq_o` stays low whatever is pending.
- R8: In the cycle after any write to address 0, `irq_o` is low. On the next cycle it rises again if a qualifying source is still pending.
- R9: Addresses 2 and 3 read as 0, and writes to them change neither the enable word nor the status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sum_i | input | 4 | Level summary interrupts of GPIO banks A..D |
| periph_evt_i | input | 6 | Peripheral event pulses, one per source |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 enable) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq_o | output | 1 | Upstream interrupt line, rising edge significant |

## Verification
The bound checker watches several rules on every cycle:
- the bank bits track their inputs one cycle later;
- a peripheral bit can only rise after its own event, and an event always leaves its bit set;
- the enable word holds unless it is written;
- the line is low after any status write, while the global enable is off, and when nothing is pending.

Only the bench scenarios show the rest:
- the exact read-back values and the bit placement of each source;
- that a masked but pending peripheral shows in status yet stays quiet on the line;
- that unmapped addresses are inert;
- the low-then-high sequence the host sees after acknowledging with work still pending.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Default geometry of the aggregator
    localparam int DEF_BANKS   = 4;
    localparam int DEF_PERIPHS = 6;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_ADDR_W  = 2;

    // Register indices
    localparam int IDX_STATUS = 0;
    localparam int IDX_ENABLE = 1;

    // Decoded register selection
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ENABLE = 2'd2
    } reg_sel_e;

    // Write strobes leaving the register port
    typedef struct packed {
        logic status_wr;
        logic enable_wr;
    } wr_stb_t;

    // Global enable lives in the top bit of the enable word
    function automatic int glb_bit(input int data_w);
        return data_w - 1;
    endfunction

endpackage

// File: rtl/irqagg_regif.sv
module irqagg_regif
    import irqagg_pkg::*;
#(
    parameter int NUM_BANKS  = DEF_BANKS,
    parameter int NUM_PERIPH = DEF_PERIPHS,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    localparam int ST_W      = NUM_BANKS + NUM_PERIPH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [ST_W-1:0]       status,
    output logic [NUM_PERIPH-1:0] pen,
    output logic                  glb_en,
    output logic [NUM_PERIPH-1:0] clr_vec,
    output wr_stb_t               stb,
    output logic [DATA_W-1:0]     rdata
);

    localparam int GB = glb_bit(DATA_W);

    reg_sel_e          sel;
    logic [DATA_W-1:0] en_word;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        if (addr == ADDR_W'(IDX_STATUS))
            sel = SEL_STATUS;
        else if (addr == ADDR_W'(IDX_ENABLE))
            sel = SEL_ENABLE;
        else
            sel = SEL_NONE;
    end

    always_comb begin
        stb.status_wr = wr_en && (sel == SEL_STATUS);
        stb.enable_wr = wr_en && (sel == SEL_ENABLE);
        clr_vec = stb.status_wr ? wdata[NUM_BANKS +: NUM_PERIPH] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pen    <= '0;
            glb_en <= 1'b0;
        end else if (stb.enable_wr) begin
            pen    <= wdata[NUM_PERIPH-1:0];
            glb_en <= wdata[GB];
        end
    end

    always_comb begin
        en_word                   = '0;
        en_word[NUM_PERIPH-1:0]   = pen;
        en_word[GB]               = glb_en;
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: rdata = {{(DATA_W-ST_W){1'b0}}, status};
            SEL_ENABLE: rdata = en_word;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqagg_pend.sv
module irqagg_pend #(
    parameter int NUM_BANKS  = irqagg_pkg::DEF_BANKS,
    parameter int NUM_PERIPH = irqagg_pkg::DEF_PERIPHS,
    localparam int ST_W      = NUM_BANKS + NUM_PERIPH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_BANKS-1:0]  bank_in,
    input  logic [NUM_PERIPH-1:0] evt_in,
    input  logic [NUM_PERIPH-1:0] clr_vec,
    output logic [ST_W-1:0]       status
);

    logic [NUM_BANKS-1:0]  bank_q;
    logic [NUM_PERIPH-1:0] pend_q;

    // Bank summaries: level copies, cleared at the bank itself
    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_in;
    end

    // Peripheral bits: sticky, event has priority over clear
    for (genvar j = 0; j < NUM_PERIPH; j++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[j] <= 1'b0;
            else if (evt_in[j])
                pend_q[j] <= 1'b1;
            else if (clr_vec[j])
                pend_q[j] <= 1'b0;
        end
    end

    assign status = {pend_q, bank_q};

endmodule

// File: rtl/irqagg_line.sv
module irqagg_line #(
    parameter int NUM_BANKS  = irqagg_pkg::DEF_BANKS,
    parameter int NUM_PERIPH = irqagg_pkg::DEF_PERIPHS,
    localparam int ST_W      = NUM_BANKS + NUM_PERIPH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ST_W-1:0]       status,
    input  logic [NUM_PERIPH-1:0] pen,
    input  logic                  glb_en,
    input  logic                  rearm,
    output logic                  irq
);

    logic [ST_W-1:0] qual;
    logic            any_src;

    assign qual    = status & {pen, {NUM_BANKS{1'b1}}};
    assign any_src = |qual;

    // A status write forces one low cycle so the host sees a new edge
    always_ff @(posedge clk) begin
        if (rst || rearm) irq <= 1'b0;
        else              irq <= glb_en && any_src;
    end

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int NUM_BANKS  = DEF_BANKS,
    parameter int NUM_PERIPH = DEF_PERIPHS,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    localparam int ST_W      = NUM_BANKS + NUM_PERIPH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_BANKS-1:0]  bank_sum_i,
    input  logic [NUM_PERIPH-1:0] periph_evt_i,
    input  logic                  reg_wr_en,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq_o
);

    logic [ST_W-1:0]       st_vec;
    logic [NUM_PERIPH-1:0] pen_vec;
    logic [NUM_PERIPH-1:0] clr_vec;
    logic                  glb_en;
    wr_stb_t               stb;

    irqagg_regif #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_PERIPH(NUM_PERIPH),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_regif (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .status (st_vec),
        .pen    (pen_vec),
        .glb_en (glb_en),
        .clr_vec(clr_vec),
        .stb    (stb),
        .rdata  (reg_rdata)
    );

    irqagg_pend #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_PERIPH(NUM_PERIPH)
    ) u_pend (
        .clk    (clk),
        .rst    (rst),
        .bank_in(bank_sum_i),
        .evt_in (periph_evt_i),
        .clr_vec(clr_vec),
        .status (st_vec)
    );

    irqagg_line #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_PERIPH(NUM_PERIPH)
    ) u_line (
        .clk   (clk),
        .rst   (rst),
        .status(st_vec),
        .pen   (pen_vec),
        .glb_en(glb_en),
        .rearm (stb.status_wr),
        .irq   (irq_o)
    );

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_PERIPH = 6,
    parameter int ADDR_W     = 2,
    localparam int ST_W      = NUM_BANKS + NUM_PERIPH
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_BANKS-1:0]  bank_sum_i,
    input logic [NUM_PERIPH-1:0] periph_evt_i,
    input logic                  reg_wr_en,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic                  irq_o,
    input logic [ST_W-1:0]       st_vec,
    input logic [NUM_PERIPH-1:0] pen_vec,
    input logic                  glb_en
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    logic [NUM_PERIPH-1:0] pend_now;
    assign pend_now = st_vec[ST_W-1:NUM_BANKS];

    AST_BANK_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        armed |-> st_vec[NUM_BANKS-1:0] == $past(bank_sum_i)); // R2

    AST_RISE_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
        armed |-> ((pend_now & ~$past(pend_now) & ~$past(periph_evt_i)) == '0)); // R3

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        armed |-> (($past(periph_evt_i) & ~pend_now) == '0)); // R4

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(reg_wr_en && reg_addr == ADDR_W'(1))
        |-> $stable(pen_vec) && $stable(glb_en)); // R5

    AST_NEED_SRC: assert property (@(posedge clk) disable iff (rst)
        armed && $past(st_vec) == '0 |-> !irq_o); // R6

    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(glb_en) |-> !irq_o); // R7

    AST_REARM_LOW: assert property (@(posedge clk) disable iff (rst)
        armed && $past(reg_wr_en && reg_addr == ADDR_W'(0)) |-> !irq_o); // R8

endmodule

bind irqagg_top irqagg_chk #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_PERIPH(NUM_PERIPH),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bank_sum_i  (bank_sum_i),
    .periph_evt_i(periph_evt_i),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .irq_o       (irq_o),
    .st_vec      (st_vec),
    .pen_vec     (pen_vec),
    .glb_en      (glb_en)
);

// File: tb/sim_irqagg_top.sv
`timescale 1ns/1ps
module sim_irqagg_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bank_sum_i = '0;
    logic [5:0]  periph_evt_i = '0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_o;

    always #10 clk = ~clk;

    irqagg_top u0 (
        .clk         (clk),
        .rst         (rst),
        .bank_sum_i  (bank_sum_i),
        .periph_evt_i(periph_evt_i),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_o       (irq_o)
    );

    typedef struct {
        string       req;
        int          sel;   // 0 read data, 1 interrupt line
        logic [15:0] exp;
    } exp_item_t;

    exp_item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_item_t it;
            logic [15:0] act;
            it  = sb_q.pop_front();
            act = (it.sel == 0) ? reg_rdata : {15'd0, irq_o};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=0x%04h expected=0x%04h", it.req, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic chk_rd(input string req, input logic [1:0] a, input logic [15:0] e);
        exp_item_t it;
        reg_addr = a;
        it.req = req; it.sel = 0; it.exp = e;
        sb_q.push_back(it);
        tick();
    endtask

    task automatic chk_irq(input string req, input logic e);
        exp_item_t it;
        it.req = req; it.sel = 1; it.exp = {15'd0, e};
        sb_q.push_back(it);
        tick();
    endtask

    task automatic pulse(input logic [5:0] v);
        periph_evt_i = v;
        tick();
        periph_evt_i = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk_rd("R1 status", 2'd0, 16'h0000);
        chk_rd("R1 enable", 2'd1, 16'h0000);
        chk_irq("R1 irq", 1'b0);

        // R2 bank bits, global off
        bank_sum_i = 4'b0101;
        tick();
        chk_rd("R2 banks A,C", 2'd0, 16'h0005);
        chk_irq("R7 global off", 1'b0);

        // R5 enable word
        wr(2'd1, 16'h8000);
        chk_rd("R5 enable rd", 2'd1, 16'h8000);
        chk_irq("R6 bank pending", 1'b1);
        wr(2'd1, 16'hFFFF);
        chk_rd("R5 unused bits zero", 2'd1, 16'h803F);
        wr(2'd1, 16'h8000);
        bank_sum_i = 4'b1000;
        tick();
        chk_rd("R2 bank D", 2'd0, 16'h0008);
        bank_sum_i = 4'b0000;
        tick(); tick();
        chk_irq("R6 nothing pending", 1'b0);

        // R3 peripheral latch, masked
        pulse(6'b000100);
        chk_rd("R3 periph2 bit6", 2'd0, 16'h0040);
        chk_irq("R6 masked source quiet", 1'b0);
        wr(2'd1, 16'h8004);
        tick();
        chk_irq("R6 enabled source", 1'b1);

        // R8 re-arm with source still pending
        wr(2'd0, 16'h0020);
        chk_irq("R8 low after status write", 1'b0);
        chk_irq("R8 fresh rise", 1'b1);
        chk_rd("R3 zero write keeps bit", 2'd0, 16'h0040);

        // R3 clear
        wr(2'd0, 16'h0040);
        chk_rd("R3 w1c clears", 2'd0, 16'h0000);
        chk_irq("R6 after clear", 1'b0);

        // R4 event vs clear in the same cycle
        pulse(6'b000001);
        periph_evt_i = 6'b000001;
        reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0010;
        tick();
        periph_evt_i = '0; reg_wr_en = 1'b0; reg_wdata = '0;
        chk_rd("R4 event wins", 2'd0, 16'h0010);

        // R7 global off with an enabled pending source
        wr(2'd1, 16'h0001);
        tick(); tick();
        chk_irq("R7 global disabled", 1'b0);
        wr(2'd1, 16'h8001);
        tick();
        chk_irq("R6 global restored", 1'b1);

        // R3 highest peripheral lands in bit 9
        pulse(6'b100000);
        chk_rd("R3 periph5 bit9", 2'd0, 16'h0210);

        // R9 unmapped addresses
        wr(2'd2, 16'hFFFF);
        wr(2'd3, 16'hFFFF);
        chk_rd("R9 addr2 reads zero", 2'd2, 16'h0000);
        chk_rd("R9 addr3 reads zero", 2'd3, 16'h0000);
        chk_rd("R9 enable untouched", 2'd1, 16'h8001);
        chk_rd("R9 status untouched", 2'd0, 16'h0210);

        // R1 reset again from a busy state
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk_rd("R1 status after reset", 2'd0, 16'h0000);
        chk_rd("R1 enable after reset", 2'd1, 16'h0000);
        chk_irq("R1 irq after reset", 1'b0);

        tick();
        done = 1;
        summary();
    end

endmodule